// File: doc/BRIEF.md
# Pipelined Radix-8 Significand Divider

This block divides one normalised single-precision significand by another by digit recurrence. Both operands arrive with their hidden bit set, so each lies in [2^23, 2^24). Each recurrence step retires three quotient bits, which makes it a radix-8 step. The block returns the integer bit of the ratio, 23 fraction bits and a guard and a round bit. A sticky bit is also returned, and it is set when the final partial remainder is nonzero. A caller tag goes in with each operand pair and comes back unchanged with that pair's result. Unpacking, special operands, exponent arithmetic, normalisation, rounding and packing are left to surrounding logic.

Two recurrence steps are chained combinationally between each pair of pipeline registers. This keeps the register count small. The first register stage also does operand setup: it compares the operands for the integer bit and subtracts the divisor when needed. For that reason it holds one step fewer than the other stages. The last stage takes whatever steps remain. With 25 result bits there are eight 3-bit steps and one 1-bit step, so the default build has five register stages. Every stage uses a valid/ready handshake. A stage refills whenever its register is empty or is being emptied in the same cycle, so a stream with no output stall flows at one result per clock.

Top module: `div8_pipe`

## Requirements
- R1: For every accepted pair, `outQuot` (26 bits) equals floor(dividend * 2^25 / divisor). Bit 25 is the integer bit and is set exactly when dividend >= divisor. Bits 1 and 0 are the guard and round bits.
- R2: `outSticky` is 1 exactly when dividend * 2^25 is not a multiple of the divisor, which means the final remainder is nonzero.
- R3: `outTag` carries the tag given with the same pair, and results leave in the order their pairs were accepted.
- R4: The block is a five-slot elastic pipeline at default parameters. An accepted pair enters the first slot, and each slot advances when the slot after it is empty or is being drained. `outValid` is high exactly when the last slot is occupied.
- R5: While `outReady` is held high, `inReady` stays high. Back-to-back valid inputs then give one result per clock after the first five cycles.
- R6: While `outValid` is high and `outReady` is low, `outValid`, `outQuot`, `outSticky` and `outTag` keep their values into the next cycle.
- R7: `inReady` is low only when all five slots are occupied and `outReady` is low.
- R8: After reset, `outValid` is 0 and `inReady` is 1.
- R9: Operand and tag values presented while `inValid` is low produce no result: once the pipeline has drained, `outValid` stays 0.
- R10: Equal operands give exactly 0x2000000 with sticky 0. Dividend 0xFFFFFF over divisor 0x800000 gives 0x3FFFFFC with sticky 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair offered |
| inReady | output | 1 | Block takes the pair this cycle |
| inDividend | input | 24 | Dividend significand, hidden bit at bit 23 |
| inDivisor | input | 24 | Divisor significand, hidden bit at bit 23 |
| inTag | input | 4 | Caller tag for the pair |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result this cycle |
| outQuot | output | 26 | Integer bit, 23 fraction bits, guard, round |
| outSticky | output | 1 | Final remainder nonzero |
| outTag | output | 4 | Tag of the pair this result belongs to |

## Verification
Accepting a new pair and holding a stalled result can happen in the same cycle. When that happens, the refill decision for each slot depends on whether the slot after it is being drained. The bench creates this overlap by offering pairs on most cycles while it drops `outReady` at random. It runs a behavioural slot model alongside the design that predicts `inReady`, `outValid` and the returned quotient, sticky bit and tag on every clock. Any lost, duplicated or reordered result therefore shows up at once as a quotient or tag mismatch.

// File: rtl/div8_pkg.sv
package div8_pkg;

  localparam int FP32_FRAC_W = 23;
  localparam int DEF_STAGES  = 5;

  // Default strobe bundle; the top redefines it for its own stage count.
  typedef struct packed {
    logic [DEF_STAGES-1:0] load;
  } defStrobe_t;

  function automatic int numSteps(input int qw, input int log2r);
    return (qw + log2r - 1) / log2r;
  endfunction

  // First stage carries setup, so it runs (comb-1) steps.
  function automatic int numStages(input int nsteps, input int comb);
    if (comb - 1 >= nsteps) return 1;
    return 1 + (nsteps - (comb - 1) + comb - 1) / comb;
  endfunction

  function automatic int stageFirst(input int s, input int comb);
    return (s == 0) ? 0 : comb * s - 1;
  endfunction

  // Exclusive end index of the steps owned by stage s.
  function automatic int stageEnd(input int s, input int comb, input int nsteps);
    int e;
    e = comb * (s + 1) - 1;
    return (e > nsteps) ? nsteps : e;
  endfunction

  // Bits produced by step idx; the last step shrinks to what is left.
  function automatic int stepBits(input int qw, input int log2r, input int idx);
    int left;
    left = qw - log2r * idx;
    return (left < log2r) ? left : log2r;
  endfunction

endpackage

// File: rtl/div8_step.sv
module div8_step #(
  parameter int SIG_W = 24,
  parameter int QO_W  = 26,
  parameter int LOG2R = 3,
  parameter int W     = 3
) (
  input  logic [SIG_W-1:0] remIn,
  input  logic [QO_W-1:0]  quoIn,
  input  logic [SIG_W-1:0] divisor,
  output logic [SIG_W-1:0] remOut,
  output logic [QO_W-1:0]  quoOut
);
  localparam int REM_W = SIG_W + LOG2R;
  localparam int DMAX  = (1 << W) - 1;

  logic [REM_W-1:0] shifted;
  logic [REM_W-1:0] best;
  logic [LOG2R-1:0] digit;

  // Restoring selection: largest multiple of the divisor not above the
  // shifted remainder.
  always_comb begin
    shifted = REM_W'(remIn) << W;
    digit   = '0;
    best    = '0;
    for (int m = 1; m <= DMAX; m++) begin
      if (shifted >= REM_W'(divisor) * REM_W'(m)) begin
        digit = LOG2R'(m);
        best  = REM_W'(divisor) * REM_W'(m);
      end
    end
    remOut = SIG_W'(shifted - best);
    quoOut = (quoIn << W) | QO_W'(digit);
  end
endmodule

// File: rtl/div8_ctrl.sv
module div8_ctrl #(
  parameter int  NST      = 5,
  parameter type strobe_t = div8_pkg::defStrobe_t
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output logic    inReady,
  input  logic    outReady,
  output logic    outValid,
  output strobe_t strobe
);
  logic [NST-1:0] full;
  logic [NST-1:0] rdy;
  logic [NST-1:0] prevValid;

  // A slot can take data if empty or if everything after it moves on.
  always_comb begin
    logic acc;
    acc = outReady;
    for (int s = NST - 1; s >= 0; s--) begin
      acc    = !full[s] || acc;
      rdy[s] = acc;
    end
  end

  assign prevValid = {full[NST-2:0], inValid};

  always_comb begin
    strobe      = '0;
    strobe.load = rdy & prevValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      full <= '0;
    end else begin
      for (int s = 0; s < NST; s++) begin
        if (rdy[s]) full[s] <= prevValid[s];
      end
    end
  end

  assign inReady  = rdy[0];
  assign outValid = full[NST-1];
endmodule

// File: rtl/div8_datapath.sv
module div8_datapath #(
  parameter int  SIG_W    = 24,
  parameter int  QW       = 25,
  parameter int  LOG2R    = 3,
  parameter int  COMB     = 2,
  parameter int  TAG_W    = 4,
  parameter int  NSTEPS   = 9,
  parameter int  NST      = 5,
  parameter type strobe_t = div8_pkg::defStrobe_t
) (
  input  logic             clk,
  input  strobe_t          strobe,
  input  logic [SIG_W-1:0] inDividend,
  input  logic [SIG_W-1:0] inDivisor,
  input  logic [TAG_W-1:0] inTag,
  output logic [QW:0]      outQuot,
  output logic             outSticky,
  output logic [TAG_W-1:0] outTag
);
  import div8_pkg::*;

  localparam int QO_W = QW + 1;

  logic             setupGe;
  logic [SIG_W-1:0] setupRem;
  logic [QO_W-1:0]  setupQuo;

  // Operand setup: integer bit and the first remainder.
  always_comb begin
    setupGe  = inDividend >= inDivisor;
    setupRem = setupGe ? (inDividend - inDivisor) : inDividend;
    setupQuo = QO_W'(setupGe);
  end

  for (genvar s = 0; s < NST; s++) begin : g_stage
    localparam int FIRST = stageFirst(s, COMB);
    localparam int LAST  = stageEnd(s, COMB, NSTEPS);

    logic [SIG_W-1:0] chRem [COMB+1];
    logic [QO_W-1:0]  chQuo [COMB+1];
    logic [SIG_W-1:0] stDiv;
    logic [TAG_W-1:0] stTag;

    logic [TAG_W-1:0] tagQ;
    logic [QO_W-1:0]  quoQ;
    logic [SIG_W-1:0] remQ;

    if (s == 0) begin : g_src
      assign chRem[0] = setupRem;
      assign chQuo[0] = setupQuo;
      assign stDiv    = inDivisor;
      assign stTag    = inTag;
    end else begin : g_src
      assign chRem[0] = g_stage[s-1].remQ;
      assign chQuo[0] = g_stage[s-1].quoQ;
      assign stDiv    = g_stage[s-1].g_keepDiv.divQ;
      assign stTag    = g_stage[s-1].tagQ;
    end

    for (genvar j = 0; j < COMB; j++) begin : g_step
      localparam int IDX = FIRST + j;
      if (IDX < LAST) begin : g_live
        div8_step #(
          .SIG_W (SIG_W),
          .QO_W  (QO_W),
          .LOG2R (LOG2R),
          .W     (stepBits(QW, LOG2R, IDX))
        ) u_step (
          .remIn   (chRem[j]),
          .quoIn   (chQuo[j]),
          .divisor (stDiv),
          .remOut  (chRem[j+1]),
          .quoOut  (chQuo[j+1])
        );
      end else begin : g_pass
        assign chRem[j+1] = chRem[j];
        assign chQuo[j+1] = chQuo[j];
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.load[s]) begin
        tagQ <= stTag;
        quoQ <= chQuo[COMB];
        remQ <= chRem[COMB];
      end
    end

    if (s < NST - 1) begin : g_keepDiv
      logic [SIG_W-1:0] divQ;
      always_ff @(posedge clk) begin
        if (strobe.load[s]) divQ <= stDiv;
      end
    end
  end

  // Final formatting: sticky from a nonzero remainder.
  assign outQuot   = g_stage[NST-1].quoQ;
  assign outSticky = |g_stage[NST-1].remQ;
  assign outTag    = g_stage[NST-1].tagQ;
endmodule

// File: rtl/div8_pipe.sv
module div8_pipe #(
  parameter int FRAC_W = div8_pkg::FP32_FRAC_W,
  parameter int LOG2R  = 3,
  parameter int COMB   = 2,
  parameter int TAG_W  = 4,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int QW     = FRAC_W + 2,
  localparam int NSTEPS = div8_pkg::numSteps(QW, LOG2R),
  localparam int NST    = div8_pkg::numStages(NSTEPS, COMB)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [SIG_W-1:0] inDividend,
  input  logic [SIG_W-1:0] inDivisor,
  input  logic [TAG_W-1:0] inTag,
  output logic             outValid,
  input  logic             outReady,
  output logic [QW:0]      outQuot,
  output logic             outSticky,
  output logic [TAG_W-1:0] outTag
);
  typedef struct packed {
    logic [NST-1:0] load;
  } strobe_t;

  strobe_t strobe;

  div8_ctrl #(
    .NST      (NST),
    .strobe_t (strobe_t)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outReady (outReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  div8_datapath #(
    .SIG_W    (SIG_W),
    .QW       (QW),
    .LOG2R    (LOG2R),
    .COMB     (COMB),
    .TAG_W    (TAG_W),
    .NSTEPS   (NSTEPS),
    .NST      (NST),
    .strobe_t (strobe_t)
  ) u_dp (
    .clk        (clk),
    .strobe     (strobe),
    .inDividend (inDividend),
    .inDivisor  (inDivisor),
    .inTag      (inTag),
    .outQuot    (outQuot),
    .outSticky  (outSticky),
    .outTag     (outTag)
  );
endmodule

// File: rtl/div8_checker.sv
module div8_checker #(
  parameter int NST   = 5,
  parameter int QO_W  = 26,
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [QO_W-1:0]  outQuot,
  input logic             outSticky,
  input logic [TAG_W-1:0] outTag
);
  localparam int CW = $clog2(NST + 1) + 1;

  logic [CW-1:0] inFlight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inFlight <= '0;
    else inFlight <= inFlight + CW'(inValid && inReady) - CW'(outValid && outReady);
  end

  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outQuot) && $stable(outSticky) && $stable(outTag)));

  a_r5_ready_when_drained: assert property (@(posedge clk) disable iff (!rstN)
    outReady |-> inReady);

  a_r7_stall_only_full: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> (inFlight == CW'(NST) && !outReady));

  a_r9_empty_no_result: assert property (@(posedge clk) disable iff (!rstN)
    (inFlight == '0) |-> !outValid);

  a_r4_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= CW'(NST));
endmodule

bind div8_pipe div8_checker #(
  .NST   (NST),
  .QO_W  (QW + 1),
  .TAG_W (TAG_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inReady   (inReady),
  .outValid  (outValid),
  .outReady  (outReady),
  .outQuot   (outQuot),
  .outSticky (outSticky),
  .outTag    (outTag)
);

// File: tb/tb_div8_pipe.sv
module tb_div8_pipe;
  localparam int SIG_W = 24;
  localparam int QO_W  = 26;
  localparam int TAG_W = 4;
  localparam int SLOTS = 5;

  logic             clk = 1'b0;
  logic             rstN;
  logic             inValid;
  logic             inReady;
  logic [SIG_W-1:0] inDividend;
  logic [SIG_W-1:0] inDivisor;
  logic [TAG_W-1:0] inTag;
  logic             outValid;
  logic             outReady;
  logic [QO_W-1:0]  outQuot;
  logic             outSticky;
  logic [TAG_W-1:0] outTag;

  always #2 clk = ~clk;

  div8_pipe dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inDividend(inDividend), .inDivisor(inDivisor), .inTag(inTag),
    .outValid(outValid), .outReady(outReady), .outQuot(outQuot),
    .outSticky(outSticky), .outTag(outTag)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural slot model.
  bit     mV [SLOTS];
  longint mQ [SLOTS];
  bit     mS [SLOTS];
  int     mT [SLOTS];
  bit     mC [SLOTS];
  longint mK [SLOTS];

  bit     prevStall = 0;
  longint prevQ;
  bit     prevS;
  int     prevT;
  int     tagCnt = 0;

  localparam int PH_NORMAL = 0;
  localparam int PH_STREAM = 1;
  localparam int PH_IDLE   = 2;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge: drive, settle, compare, advance the model.
  task automatic cycle(input bit v, input logic [SIG_W-1:0] a, input logic [SIG_W-1:0] b,
                       input bit ordy, input int ph, input bit corner, input longint cornerQ,
                       input bit streamFull);
    int     occ;
    bit     expRdy;
    bit     acc;
    bit     rdy [SLOTS];
    longint num;
    inValid    = v;
    inDividend = a;
    inDivisor  = b;
    inTag      = TAG_W'(tagCnt);
    outReady   = ordy;
    #1;
    occ = 0;
    for (int s = 0; s < SLOTS; s++) occ += int'(mV[s]);
    expRdy = ordy || (occ < SLOTS);
    check(inReady == expRdy, "R7 inReady", longint'(inReady), longint'(expRdy));
    if (ph == PH_STREAM) check(inReady == 1'b1, "R5 inReady", longint'(inReady), 1);
    if (streamFull) check(outValid == 1'b1, "R5 outValid", longint'(outValid), 1);
    check(outValid == mV[SLOTS-1], "R4 outValid", longint'(outValid), longint'(mV[SLOTS-1]));
    if (ph == PH_IDLE) check(outValid == 1'b0, "R9 outValid", longint'(outValid), 0);
    if (outValid && mV[SLOTS-1]) begin
      check(longint'(outQuot) == mQ[SLOTS-1], "R1 quotient", longint'(outQuot), mQ[SLOTS-1]);
      check(outSticky == mS[SLOTS-1], "R2 sticky", longint'(outSticky), longint'(mS[SLOTS-1]));
      check(int'(outTag) == mT[SLOTS-1], "R3 tag", longint'(outTag), longint'(mT[SLOTS-1]));
      if (mC[SLOTS-1]) begin
        check(longint'(outQuot) == mK[SLOTS-1], "R10 quotient", longint'(outQuot), mK[SLOTS-1]);
        check(outSticky == 1'b0, "R10 sticky", longint'(outSticky), 0);
      end
    end
    if (prevStall) begin
      check(outValid == 1'b1, "R6 valid held", longint'(outValid), 1);
      check(longint'(outQuot) == prevQ && outSticky == prevS && int'(outTag) == prevT,
            "R6 data held", longint'(outQuot), prevQ);
    end
    prevStall = outValid && !ordy;
    prevQ = longint'(outQuot);
    prevS = outSticky;
    prevT = int'(outTag);
    // advance model to the state after the coming rising edge
    acc = ordy;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      acc = !mV[s] || acc;
      rdy[s] = acc;
    end
    for (int s = SLOTS - 1; s >= 1; s--) begin
      if (rdy[s]) begin
        mV[s] = mV[s-1]; mQ[s] = mQ[s-1]; mS[s] = mS[s-1];
        mT[s] = mT[s-1]; mC[s] = mC[s-1]; mK[s] = mK[s-1];
      end
    end
    if (rdy[0]) begin
      num   = longint'(a) << 25;
      mV[0] = v;
      mQ[0] = (b != 0) ? num / longint'(b) : 0;
      mS[0] = (b != 0) ? ((num % longint'(b)) != 0) : 1'b0;
      mT[0] = tagCnt;
      mC[0] = corner;
      mK[0] = cornerQ;
      if (v) tagCnt = (tagCnt + 1) % (1 << TAG_W);
    end
    @(negedge clk);
  endtask

  function automatic logic [SIG_W-1:0] randSig();
    return {1'b1, 23'($urandom)};
  endfunction

  initial begin
    for (int s = 0; s < SLOTS; s++) begin
      mV[s] = 0; mQ[s] = 0; mS[s] = 0; mT[s] = 0; mC[s] = 0; mK[s] = 0;
    end
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b0;
    inDividend = '0; inDivisor = '0; inTag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(outValid == 1'b0, "R8 outValid", longint'(outValid), 0);
    check(inReady == 1'b1, "R8 inReady", longint'(inReady), 1);
    @(negedge clk);

    // R10 corner operands
    cycle(1, 24'hC00001, 24'hC00001, 1, PH_NORMAL, 1, 64'h2000000, 0);
    cycle(1, 24'h800000, 24'h800000, 1, PH_NORMAL, 1, 64'h2000000, 0);
    cycle(1, 24'hFFFFFF, 24'h800000, 1, PH_NORMAL, 1, 64'h3FFFFFC, 0);
    cycle(1, 24'h800000, 24'hFFFFFF, 1, PH_NORMAL, 0, 0, 0);
    repeat (8) cycle(0, '0, '0, 1, PH_NORMAL, 0, 0, 0);

    // R5 back-to-back stream
    for (int i = 0; i < 80; i++)
      cycle(1, randSig(), randSig(), 1, PH_STREAM, 0, 0, i >= SLOTS);
    repeat (8) cycle(0, '0, '0, 1, PH_NORMAL, 0, 0, 0);

    // random valid and random output stalls
    for (int i = 0; i < 1500; i++)
      cycle(($urandom % 10) < 7, randSig(), randSig(), ($urandom % 2) == 0,
            PH_NORMAL, 0, 0, 0);
    // long stall to fill the pipe, then release
    for (int i = 0; i < 12; i++)
      cycle(1, randSig(), randSig(), 0, PH_NORMAL, 0, 0, 0);
    repeat (12) cycle(0, '0, '0, 1, PH_NORMAL, 0, 0, 0);

    // R9 idle with junk operands
    for (int i = 0; i < 20; i++)
      cycle(0, randSig(), randSig(), ($urandom % 2) == 0, PH_IDLE, 0, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule